// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a register-mapped timer that produces a steady tick for an operating system or a firmware scheduler. A fixed prescaler divides the input clock by sixteen. Each prescaled tick advances a 20-bit interval value that runs from zero up to a programmed limit and then returns to zero. Every such return sets a status flag and adds one to a 12-bit count of elapsed periods. If software is slow to service the timer, it can read that count to find out how many periods it missed.

Software reaches the timer through a small synchronous bus with four word registers: a control word, a status word, and two views of the packed counter state. The acknowledging view clears the flag and the elapsed-period count as it is read. The snapshot view returns the same word and changes nothing. The level interrupt output follows the flag while interrupts are enabled. When the timer is switched off, the current period runs to its end and the value then stays at zero. Software can poll for that zero to know the timer has stopped.

Top module: `pit_timer`

## Requirements
- R1: After reset every readable word (offsets 0x0, 0x4, 0x8, 0xC) reads as zero and `irq` is low.
- R2: While running, the interval value changes exactly once every 16 clock cycles, counted from the end of reset.
- R3: The interval value counts up by one per tick and, on the tick where it equals the programmed limit, returns to zero. A full period is therefore limit+1 ticks.
- R4: Every return to zero sets bit 0 of the status word at offset 0x4. Reading offset 0x4 changes no state.
- R5: Each return to zero adds one to the 12-bit elapsed-period count, which wraps modulo 4096.
- R6: A read of offset 0x8 returns the count in bits 31:20 and the interval value in bits 19:0. The read then clears the status bit and the count.
- R7: A read of offset 0xC returns the same packed word as offset 0x8 and leaves the status bit and the count unchanged.
- R8: When an acknowledging read of 0x8 falls on the same cycle as a return to zero, the read returns the values from before the wrap. Afterwards the status bit is 1 and the count is 1.
- R9: When the run bit is cleared, the interval value keeps counting until it next reaches zero and then holds at zero.
- R10: `irq` is high exactly while the status bit is 1 and the interrupt-enable bit is 1. Clearing interrupt-enable does not stop counting.
- R11: The control word at offset 0x0 holds interrupt-enable in bit 25, run in bit 24 and the limit in bits 19:0. It reads back with all other bits zero. Writes to offsets 0x4, 0x8 and 0xC are ignored.
- R12: Read data is registered and appears on `bus_rdata` in the cycle after `bus_rd_en` is sampled. `bus_rdata` holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also feeds the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wr_en | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rd_en | input | 1 | Read strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bound checker watches several rules on every cycle. The interval value holds between prescaled ticks and returns to zero after each wrap. A wrap always sets the flag, and the elapsed-period count steps by one on an unacknowledged wrap. The two read views act correctly, including when an acknowledging read lands on a wrap. A stopped timer stays at zero, and the interrupt never rises without both the flag and its enable. Other behaviour can only be shown by the bench's scenarios, which compare every read word against an independent model: the exact read values, control-word readback, writes that are ignored, the run-out to zero after disable, and the count wrapping after 4096 periods.

// File: rtl/pit_pkg.sv
package pit_pkg;
   // Register byte offsets
   localparam int unsigned OFS_CTRL  = 4'h0;
   localparam int unsigned OFS_FLAG  = 4'h4;
   localparam int unsigned OFS_TAKE  = 4'h8;
   localparam int unsigned OFS_PEEK  = 4'hC;

   // Control word bit positions
   localparam int unsigned CTRL_IEN_BIT = 25;
   localparam int unsigned CTRL_RUN_BIT = 24;

   typedef enum logic [2:0] {
      SEL_CTRL,
      SEL_FLAG,
      SEL_TAKE,
      SEL_PEEK,
      SEL_NONE
   } reg_sel_e;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
   parameter int unsigned DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("pit_prescaler: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] phase;
         assign tick = (phase == PW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    phase <= '0;
            else if (tick) phase <= '0;
            else           phase <= phase + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pit_interval.sv
module pit_interval #(
   parameter int unsigned CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] value,
   output logic             wrap
);
   logic active;

   // A cleared run bit lets the current period finish, then parks at zero.
   assign active = run || (value != '0);
   assign wrap   = tick && active && (value >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                value <= '0;
      else if (wrap)             value <= '0;
      else if (tick && active)   value <= value + 1'b1;
   end
endmodule

// File: rtl/pit_overflow.sv
module pit_overflow #(
   parameter int unsigned OVF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wrap,
   input  logic             take,
   output logic [OVF_W-1:0] periods,
   output logic             flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         periods <= '0;
      end else if (take) begin
         // An acknowledge that meets a wrap keeps the new wrap.
         flag    <= wrap;
         periods <= wrap ? OVF_W'(1) : '0;
      end else if (wrap) begin
         flag    <= 1'b1;
         periods <= periods + 1'b1;
      end
   end
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
   parameter int unsigned DIV    = 16,
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned OVF_W  = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd_en,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   import pit_pkg::*;

   generate
      if (CNT_W + OVF_W != DATA_W) begin : g_bad_pack
         $error("pit_timer: CNT_W + OVF_W must equal DATA_W");
      end
      if (CNT_W > CTRL_RUN_BIT) begin : g_bad_cnt
         $error("pit_timer: limit field overlaps control bits");
      end
      if (DATA_W <= CTRL_IEN_BIT) begin : g_bad_data
         $error("pit_timer: DATA_W too narrow for control bits");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("pit_timer: ADDR_W must be at least 4");
      end
   endgenerate

   logic             ctl_ien;
   logic             ctl_run;
   logic [CNT_W-1:0] ctl_limit;
   logic             tick;
   logic             wrap;
   logic [CNT_W-1:0] value;
   logic [OVF_W-1:0] periods;
   logic             flag;
   logic             take;
   reg_sel_e         sel;
   logic [DATA_W-1:0] rd_word;
   logic             wdata_unused;

   assign wdata_unused = ^bus_wdata;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_CTRL)) sel = SEL_CTRL;
      else if (bus_addr == ADDR_W'(OFS_FLAG)) sel = SEL_FLAG;
      else if (bus_addr == ADDR_W'(OFS_TAKE)) sel = SEL_TAKE;
      else if (bus_addr == ADDR_W'(OFS_PEEK)) sel = SEL_PEEK;
      else                                    sel = SEL_NONE;
   end

   assign take = bus_rd_en && (sel == SEL_TAKE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_ien   <= 1'b0;
         ctl_run   <= 1'b0;
         ctl_limit <= '0;
      end else if (bus_wr_en && sel == SEL_CTRL) begin
         ctl_ien   <= bus_wdata[CTRL_IEN_BIT];
         ctl_run   <= bus_wdata[CTRL_RUN_BIT];
         ctl_limit <= bus_wdata[CNT_W-1:0];
      end
   end

   pit_prescaler #(.DIV(DIV)) u_presc (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   pit_interval #(.CNT_W(CNT_W)) u_interval (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick),
      .run  (ctl_run),
      .limit(ctl_limit),
      .value(value),
      .wrap (wrap)
   );

   pit_overflow #(.OVF_W(OVF_W)) u_overflow (
      .clk    (clk),
      .rst_n  (rst_n),
      .wrap   (wrap),
      .take   (take),
      .periods(periods),
      .flag   (flag)
   );

   always_comb begin
      rd_word = '0;
      unique case (sel)
         SEL_CTRL: begin
            rd_word[CTRL_IEN_BIT] = ctl_ien;
            rd_word[CTRL_RUN_BIT] = ctl_run;
            rd_word[CNT_W-1:0]    = ctl_limit;
         end
         SEL_FLAG:           rd_word[0] = flag;
         SEL_TAKE, SEL_PEEK: rd_word    = {periods, value};
         default:            rd_word    = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bus_rdata <= '0;
      else if (bus_rd_en) bus_rdata <= rd_word;
   end

   assign irq = flag && ctl_ien;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
   parameter int unsigned CNT_W  = 20,
   parameter int unsigned OVF_W  = 12,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic              tick,
   input logic              wrap,
   input logic [CNT_W-1:0]  value,
   input logic [OVF_W-1:0]  periods,
   input logic              flag,
   input logic              run,
   input logic              ien,
   input logic              irq
);
   import pit_pkg::*;

   logic take_rd;
   logic peek_rd;
   assign take_rd = rd_en && (addr == ADDR_W'(OFS_TAKE));
   assign peek_rd = rd_en && (addr == ADDR_W'(OFS_PEEK));

   p_hold_off_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(value));

   p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (value == '0));

   p_wrap_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> flag);

   p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !take_rd) |=> (periods == OVF_W'($past(periods) + 1'b1)));

   p_take_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (take_rd && !wrap) |=> (!flag && periods == '0));

   p_peek_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (peek_rd && !wrap) |=> ($stable(flag) && $stable(periods)));

   p_take_meets_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (take_rd && wrap) |=> (flag && periods == OVF_W'(1)));

   p_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && value == '0) |=> (value == '0));

   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ien && flag));
endmodule

bind pit_timer pit_timer_chk #(
   .CNT_W (CNT_W),
   .OVF_W (OVF_W),
   .ADDR_W(ADDR_W)
) chk_i (
   .clk    (clk),
   .rst_n  (rst_n),
   .rd_en  (bus_rd_en),
   .addr   (bus_addr),
   .tick   (tick),
   .wrap   (wrap),
   .value  (value),
   .periods(periods),
   .flag   (flag),
   .run    (ctl_run),
   .ien    (ctl_ien),
   .irq    (irq)
);

// File: tb/pit_timer_tb_top.sv
module pit_timer_tb_top;
   typedef struct {
      logic [31:0] exp;
      string       tag;
   } sb_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr_en = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd_en = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";
   sb_item_t sb_q[$];

   // Reference state, built from the requirements
   logic [3:0]  m_ph;
   logic [19:0] m_val;
   logic [11:0] m_cnt;
   logic        m_flag, m_run, m_ien;
   logic [19:0] m_lim;

   always #2 clk = ~clk;

   pit_timer dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wr_en(bus_wr_en),
      .bus_wdata(bus_wdata),
      .bus_rd_en(bus_rd_en),
      .bus_rdata(bus_rdata),
      .irq      (irq)
   );

   function automatic logic [31:0] model_word(input logic [3:0] a);
      case (a)
         4'h0:       return {6'b0, m_ien, m_run, 4'b0, m_lim};
         4'h4:       return {31'b0, m_flag};
         4'h8, 4'hC: return {m_cnt, m_val};
         default:    return 32'h0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = '0; m_val = '0; m_cnt = '0; m_flag = 1'b0;
         m_run = 1'b0; m_ien = 1'b0; m_lim = '0;
      end else begin
         logic t, act, w, tk;
         sb_item_t it;
         if (bus_rd_en) begin
            it.exp = model_word(bus_addr);
            it.tag = cur_tag;
            sb_q.push_back(it);
         end
         t   = (m_ph == 4'd15);
         act = m_run || (m_val != 0);
         w   = t && act && (m_val >= m_lim);
         tk  = bus_rd_en && bus_addr == 4'h8;
         m_ph = m_ph + 1'b1;
         if (w) m_val = '0;
         else if (t && act) m_val = m_val + 1'b1;
         if (tk) begin
            m_flag = w;
            m_cnt  = w ? 12'd1 : 12'd0;
         end else if (w) begin
            m_flag = 1'b1;
            m_cnt  = m_cnt + 1'b1;
         end
         if (bus_wr_en && bus_addr == 4'h0) begin
            m_ien = bus_wdata[25];
            m_run = bus_wdata[24];
            m_lim = bus_wdata[19:0];
         end
      end
   end

   // Scoreboard monitor: compares read data one cycle after the strobe (R12)
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         it = sb_q.pop_front();
         checks++;
         if (bus_rdata !== it.exp) begin
            errors++;
            $display("FAIL %s: bus_rdata actual=%08h expected=%08h", it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
      @(negedge clk);
      bus_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input string tag);
      @(negedge clk);
      cur_tag = tag; bus_addr = a; bus_rd_en = 1'b1;
      @(negedge clk);
      bus_rd_en = 1'b0;
   endtask

   task automatic check_irq(input string tag);
      logic e;
      e = m_flag && m_ien;
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s: irq actual=%b expected=%b", tag, irq, e);
      end
   endtask

   task automatic check_val(input string tag, input logic [19:0] act, input logic [19:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: value actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check_irq("R1");
      rd(4'h0, "R1"); rd(4'h4, "R1"); rd(4'h8, "R1"); rd(4'hC, "R1");

      // R11: control readback, reserved bits dropped
      wr(4'h0, 32'hFCF0_0004 | 32'h0100_0000);
      rd(4'h0, "R11");
      wr(4'h0, 32'h0100_0004);   // run, limit 4, interrupts off
      // R2, R3: snapshot reads through several periods
      for (int i = 0; i < 12; i++) begin
         repeat (13) @(negedge clk);
         rd(4'hC, "R2");
      end
      rd(4'hC, "R7");
      rd(4'h4, "R4");
      rd(4'h4, "R4");
      rd(4'hC, "R5");
      // R6: acknowledge, then confirm cleared
      rd(4'h8, "R6");
      rd(4'hC, "R6");
      rd(4'h4, "R6");
      // R11: writes to other offsets ignored
      repeat (100) @(negedge clk);
      wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'hC, 32'hFFFF_FFFF);
      rd(4'h4, "R11");
      rd(4'hC, "R11");
      rd(4'h0, "R11");

      // R8: acknowledging read on the wrap edge
      rd(4'h8, "R8");
      do @(negedge clk); while (!(m_ph == 4'd15 && m_val >= m_lim));
      cur_tag = "R8"; bus_addr = 4'h8; bus_rd_en = 1'b1;
      @(negedge clk);
      bus_rd_en = 1'b0;
      rd(4'h4, "R8");
      rd(4'hC, "R8");

      // R10: interrupt gating
      wr(4'h0, 32'h0300_0004);
      check_irq("R10");
      rd(4'h8, "R10");
      check_irq("R10");
      repeat (90) @(negedge clk);
      check_irq("R10");
      wr(4'h0, 32'h0100_0004);
      check_irq("R10");
      rd(4'hC, "R10");
      repeat (40) @(negedge clk);
      rd(4'hC, "R10");

      // R9: disable mid-period, run out, then park at zero
      wr(4'h0, 32'h0100_0009);
      do @(negedge clk); while (m_val != 20'd3);
      wr(4'h0, 32'h0000_0009);
      repeat (20) @(negedge clk);
      rd(4'hC, "R9");
      repeat (200) @(negedge clk);
      rd(4'hC, "R9");
      check_val("R9", m_val, 20'd0);
      repeat (100) @(negedge clk);
      rd(4'hC, "R9");

      // R5: count wraps modulo 4096 with limit 0
      rd(4'h8, "R5");
      wr(4'h0, 32'h0100_0000);
      repeat (4100 * 16) @(negedge clk);
      rd(4'hC, "R5");
      rd(4'h4, "R5");

      finish_run();
   end
endmodule